// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 1-kbit serial EEPROM behind a three-wire select/clock/data-in interface with a separate data-out pin and its enable. After a start bit, the host shifts in a two-bit opcode, an address and, for program commands, a data word. Reads return a leading zero bit followed by the addressed word, and carry on through the following addresses for as long as the host keeps clocking. Program commands change the register-based array at once. They then hold the block busy for a programmable number of system clock cycles, which stands in for the cell programming time.

A strap input picks the organisation: 64 words of 16 bits, or 128 bytes with one extra address bit. All program commands are blocked after reset. A write-enable command opens them and a write-disable command closes them again. The serial inputs are assumed to be synchronous to `clk` and much slower than it. The serial clock is sampled by `clk`, and its rising edges are detected inside the block.

Top module: `mw_eeprom`

## Requirements
- R1: A command begins only at the first serial-clock rising edge where `cs` and `di` are both high. Rising edges with `di` low, and any activity while `cs` is low, start nothing. Bits are taken MSB first on rising edges in this order: start bit, two opcode bits, address, then data when the command needs it.
- R2: The opcode codes are 10 for read, 01 for write and 11 for erase. Code 00 uses the top two address bits as a sub-code: 11 enables programming, 00 disables it, 10 erases all locations and 01 writes all locations.
- R3: After reset, programming is disabled. A program command issued while disabled leaves the array unchanged and never drives `so_en`. An enable command allows programming and a disable command blocks it again.
- R4: On a read, the rising edge that takes the last address bit asserts `so_en` with `so` = 0. Each later rising edge presents the next data bit, MSB first.
- R5: If clocking continues after the last bit of a word, the read moves on to the next address. It wraps from the last location to location 0.
- R6: With `org` high, words are 16 bits wide and there are 6 address bits. With `org` low, words are 8 bits wide and there are 7 address bits. Byte address b maps to bits [7:0] of word b/2 when b is even and to bits [15:8] when b is odd.
- R7: Erase sets the addressed location to all ones. Erase-all sets every location to all ones. Write-all writes the data to every location.
- R8: If `cs` falls before the last bit a command needs, the command has no effect.
- R9: Once a program command is accepted, `so_en` is driven while `cs` stays high. `so` reads 0 for BUSY_TICKS clock cycles and then reads 1.
- R10: `so_en` is low whenever `cs` is low, so a fall of `cs` releases the output at once.
- R11: A start bit received while busy is ignored until `cs` goes low, so that command has no effect.
- R12: After reset, `so_en` is low and every location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by `clk` |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation strap: 1 selects 16-bit words, 0 selects bytes |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The assertions check every cycle that a program start never coincides with busy, that the busy counter loads on a start and then counts down one per cycle, that the protection latch is clear straight after reset, and that every read opens with a zero bit. The bench scenarios are needed for everything that depends on array contents or on the whole serial frame. That covers data written and read back in both organisations, the byte-to-word mapping, wrap-around in a sequential read, aborted frames, protected and busy-time commands having no effect, and the length of the busy window as seen on `so`.

// File: rtl/mw_pkg.sv
// Package: shared state type and command codes for the serial EEPROM slave.
// Assumes: nothing beyond IEEE 1800-2017.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_WAIT
    } mw_state_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_WEN   = 2'b11;

endpackage

// File: rtl/mw_busy_timer.sv
// Module: mw_busy_timer
// Stands in for the nonvolatile programming time. A start pulse loads
// TICKS, the count falls by one per clock, and busy is high while the
// count is non-zero.
// Assumes: start is a single-cycle pulse that never arrives while busy.
module mw_busy_timer #(
    parameter int TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start)       cnt_q <= CW'(TICKS);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R9
    busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mw_array.sv
// Module: mw_array
// Register-based storage of WORDS x WBITS with two byte lanes. One write
// port can hit a single word or every word at once. The read port is
// combinational.
// Assumes: WBITS is even. Reset models the erased (all ones) state.
module mw_array #(
    parameter int WORDS = 64,
    parameter int WBITS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_all,
    input  logic [$clog2(WORDS)-1:0] wr_idx,
    input  logic [1:0]               wr_lane,
    input  logic [WBITS-1:0]         wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [WBITS-1:0]         rd_word
);
    localparam int IW = $clog2(WORDS);
    localparam int HB = WBITS / 2;

    logic [WBITS-1:0] cells [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [WBITS-1:0] cell_q;
        logic             hit;

        assign hit = wr_en && (wr_all || (wr_idx == IW'(gi)));

        // Update the enabled byte lanes of this word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (hit) begin
                if (wr_lane[0]) cell_q[HB-1:0]     <= wr_data[HB-1:0];
                if (wr_lane[1]) cell_q[WBITS-1:HB] <= wr_data[WBITS-1:HB];
            end
        end

        assign cells[gi] = cell_q;
    end

    assign rd_word = cells[rd_idx];

endmodule

// File: rtl/mw_serial_ctrl.sv
// Module: mw_serial_ctrl
// Serial front end: detects serial clock edges, qualifies the start bit,
// collects opcode, address and data, decodes commands, drives the array
// write port, and shifts read data or ready status out.
// Assumes: cs, sk, di are synchronous to clk, and each sk level lasts at
// least two clk cycles.
module mw_serial_ctrl
    import mw_pkg::*;
#(
    parameter int AW16  = 6,
    parameter int WBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sk,
    input  logic             di,
    input  logic             org,
    input  logic             busy,
    input  logic [WBITS-1:0] rd_word,
    output logic [AW16-1:0]  rd_idx,
    output logic             mem_we,
    output logic             mem_all,
    output logic [AW16-1:0]  mem_idx,
    output logic [1:0]       mem_lane,
    output logic [WBITS-1:0] mem_wdata,
    output logic             prog_start,
    output logic             so,
    output logic             so_en
);
    localparam int AWB  = AW16 + 1;
    localparam int HB   = WBITS / 2;
    localparam int CNTW = $clog2(WBITS + AWB + 1);

    mw_state_e        state;
    logic             sk_q;
    logic [CNTW-1:0]  bit_cnt;
    logic [1:0]       op_q;
    logic [AWB-1:0]   addr_q;
    logic [WBITS-1:0] data_q;
    logic [WBITS-1:0] rd_sh;
    logic             so_q;
    logic             wen_q;

    logic             sk_rise;
    logic [CNTW-1:0]  aw_now, dw_now;
    logic [AWB-1:0]   addr_next, addr_sel, addr_inc;
    logic [WBITS-1:0] data_next, rd_aligned;
    logic [HB-1:0]    rd_byte;
    logic [1:0]       ext_code;
    logic             last_addr, last_data;
    logic             do_erase, do_eral, do_write, do_wral;

    // Rising edge of the serial clock, qualified by chip select.
    assign sk_rise = sk && !sk_q && cs;

    // Field lengths for the current organisation.
    assign aw_now = org ? CNTW'(AW16)  : CNTW'(AWB);
    assign dw_now = org ? CNTW'(WBITS) : CNTW'(HB);

    // Shift values including the bit sampled this edge.
    assign addr_next = {addr_q[AWB-2:0], di};
    assign data_next = {data_q[WBITS-2:0], di};
    assign ext_code  = org ? addr_next[AW16-1:AW16-2] : addr_next[AWB-1:AWB-2];

    // Frame completion points.
    assign last_addr = (state == ST_ADDR) && sk_rise && (bit_cnt == aw_now - 1'b1);
    assign last_data = (state == ST_DATA) && sk_rise && (bit_cnt == dw_now - 1'b1);

    // Program command decode at the final bit.
    assign do_erase = last_addr && (op_q == OPC_ERASE);
    assign do_eral  = last_addr && (op_q == OPC_EXT) && (ext_code == EXT_ERALL);
    assign do_write = last_data && (op_q == OPC_WRITE);
    assign do_wral  = last_data && (op_q == OPC_EXT);

    // Array write port: gated by the protection latch.
    assign mem_we     = wen_q && (do_erase || do_eral || do_write || do_wral);
    assign mem_all    = do_eral || do_wral;
    assign prog_start = mem_we;
    assign addr_sel   = last_addr ? addr_next : addr_q;
    assign mem_idx    = org ? addr_sel[AW16-1:0] : addr_sel[AWB-1:1];

    // Lane choice: whole word in x16 mode or for the all-location commands.
    always_comb begin
        if (org || mem_all) mem_lane = 2'b11;
        else                mem_lane = addr_sel[0] ? 2'b10 : 2'b01;
    end

    // Write data: ones for erase, byte copied to both lanes in x8 mode.
    always_comb begin
        if (do_erase || do_eral) mem_wdata = '1;
        else if (org)            mem_wdata = data_next;
        else                     mem_wdata = {2{data_next[HB-1:0]}};
    end

    // Read port and left-aligned read value for the current organisation.
    assign rd_idx     = org ? addr_q[AW16-1:0] : addr_q[AWB-1:1];
    assign rd_byte    = addr_q[0] ? rd_word[WBITS-1:HB] : rd_word[HB-1:0];
    assign rd_aligned = org ? rd_word : {rd_byte, {HB{1'b0}}};
    assign addr_inc   = org ? {1'b0, AW16'(addr_q[AW16-1:0] + 1'b1)} : addr_q + 1'b1;

    // Command sequencer: start detection, field collection, decode, read shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sk_q    <= 1'b0;
            bit_cnt <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_sh   <= '0;
            so_q    <= 1'b0;
            wen_q   <= 1'b0;
        end else begin
            sk_q <= sk;
            if (!cs) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (sk_rise) begin
                case (state)
                    ST_IDLE: begin
                        if (di) begin
                            state   <= busy ? ST_WAIT : ST_OP;
                            bit_cnt <= '0;
                            addr_q  <= '0;
                            data_q  <= '0;
                        end
                    end
                    ST_OP: begin
                        op_q <= {op_q[0], di};
                        if (bit_cnt == CNTW'(1)) begin
                            state   <= ST_ADDR;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_next;
                        if (last_addr) begin
                            bit_cnt <= '0;
                            case (op_q)
                                OPC_READ: begin
                                    state   <= ST_READ;
                                    so_q    <= 1'b0;
                                    bit_cnt <= dw_now;
                                end
                                OPC_WRITE: state <= ST_DATA;
                                OPC_ERASE: state <= mem_we ? ST_STATUS : ST_WAIT;
                                default: begin
                                    case (ext_code)
                                        EXT_WEN: begin
                                            wen_q <= 1'b1;
                                            state <= ST_WAIT;
                                        end
                                        EXT_WDIS: begin
                                            wen_q <= 1'b0;
                                            state <= ST_WAIT;
                                        end
                                        EXT_ERALL: state <= mem_we ? ST_STATUS : ST_WAIT;
                                        default:   state <= ST_DATA;
                                    endcase
                                end
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_q <= data_next;
                        if (last_data) state <= mem_we ? ST_STATUS : ST_WAIT;
                        else           bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_READ: begin
                        if (bit_cnt == dw_now) begin
                            so_q    <= rd_aligned[WBITS-1];
                            rd_sh   <= {rd_aligned[WBITS-2:0], 1'b0};
                            bit_cnt <= CNTW'(1);
                        end else begin
                            so_q    <= rd_sh[WBITS-1];
                            rd_sh   <= {rd_sh[WBITS-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == dw_now - 1'b1) addr_q <= addr_inc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output driver: released at once when cs is low.
    assign so_en = cs && ((state == ST_READ) || (state == ST_STATUS));
    assign so    = (state == ST_STATUS) ? !busy : so_q;

    // R11
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);

    // R3
    wen_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !wen_q);

    // R4
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_READ) |-> !so);

    // R9
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == ST_STATUS));

endmodule

// File: rtl/mw_eeprom.sv
// Module: mw_eeprom (top)
// Serial EEPROM slave: links the serial controller to the storage array
// and to the programming-time counter.
// Assumes: WORDS is a power of two, WBITS is even, serial inputs are
// synchronous to clk.
module mw_eeprom #(
    parameter int WORDS      = 64,
    parameter int WBITS      = 16,
    parameter int BUSY_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic so,
    output logic so_en
);
    localparam int AW16 = $clog2(WORDS);

    logic             busy;
    logic             prog_start;
    logic             mem_we, mem_all;
    logic [AW16-1:0]  mem_idx, rd_idx;
    logic [1:0]       mem_lane;
    logic [WBITS-1:0] mem_wdata, rd_word;

    mw_serial_ctrl #(.AW16(AW16), .WBITS(WBITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .busy(busy), .rd_word(rd_word), .rd_idx(rd_idx),
        .mem_we(mem_we), .mem_all(mem_all), .mem_idx(mem_idx),
        .mem_lane(mem_lane), .mem_wdata(mem_wdata),
        .prog_start(prog_start), .so(so), .so_en(so_en)
    );

    mw_array #(.WORDS(WORDS), .WBITS(WBITS)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wr_all(mem_all),
        .wr_idx(mem_idx), .wr_lane(mem_lane), .wr_data(mem_wdata),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    mw_busy_timer #(.TICKS(BUSY_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int CLK_NS = 10;
    localparam int BUSY   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic so, so_en;
    int   n_checks = 0, n_errors = 0;
    logic done = 1'b0;
    logic s_so, s_en;

    mw_eeprom #(.WORDS(64), .WBITS(16), .BUSY_TICKS(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .so(so), .so_en(so_en)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk) di = b;
        @(negedge clk) sk = 1'b1;
        @(negedge clk);
        @(negedge clk) begin s_so = so; s_en = so_en; sk = 1'b0; end
        @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk) cs = 1'b1;
        @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk) cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    function automatic int aw(); return org ? 6 : 7; endfunction
    function automatic int dw(); return org ? 16 : 8; endfunction

    task automatic frame(input logic [1:0] op, input logic [6:0] a);
        pulse(1'b1);
        send({14'd0, op}, 2);
        send({9'd0, a}, aw());
    endtask

    // Program command; checks status or silence, waits for ready.
    task automatic prog(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d,
                        input bit has_data, input bit accept, input string req);
        cs_on();
        frame(op, a);
        if (has_data) send(d, dw());
        if (accept) begin
            chk(s_en && !s_so, req, {s_en, s_so}, 2);
            for (int i = 0; i < 200 && !so; i++) @(negedge clk);
            chk(so_en && so, req, {so_en, so}, 3);
        end else begin
            chk(!s_en, req, s_en, 0);
        end
        cs_off();
    endtask

    task automatic rd(input logic [6:0] a, input int nbits, output logic [31:0] v, input string req);
        cs_on();
        frame(2'b10, a);
        chk(s_en && !s_so, req, {s_en, s_so}, 2);
        v = '0;
        for (int i = 0; i < nbits; i++) begin
            pulse(1'b0);
            v = {v[30:0], s_so};
        end
        cs_off();
    endtask

    task automatic expect_word(input logic [6:0] a, input logic [15:0] e, input string req);
        logic [31:0] v;
        rd(a, dw(), v, req);
        chk(v[15:0] == e, req, v[15:0], e);
    endtask

    task automatic t_reset();
        chk(!so_en, "R12", so_en, 0);
        expect_word(7'd0, 16'hFFFF, "R12");
        expect_word(7'd63, 16'hFFFF, "R12");
    endtask

    task automatic t_start_qual();
        // R1: activity with cs low, then leading zeros, then a valid read
        repeat (3) begin @(negedge clk) di = 1'b1; sk = 1'b1; repeat (2) @(negedge clk); sk = 1'b0; @(negedge clk); end
        chk(!so_en, "R1", so_en, 0);
        cs_on();
        send(16'h0, 4);
        chk(!s_en, "R1", s_en, 0);
        frame(2'b10, 7'd1);
        chk(s_en && !s_so, "R1", {s_en, s_so}, 2);
        cs_off();
    endtask

    task automatic t_protect();
        prog(2'b01, 7'd5, 16'h1234, 1, 0, "R3");
        expect_word(7'd5, 16'hFFFF, "R3");
    endtask

    task automatic t_write_busy();
        int cyc;
        prog(2'b00, 7'h30, 16'h0, 0, 0, "R2");
        cs_on();
        frame(2'b01, 7'd5);
        send(16'h1234, 16);
        chk(s_en && !s_so, "R9", {s_en, s_so}, 2);
        cyc = 0;
        while (!so && cyc < 200) begin @(negedge clk); cyc++; end
        chk(cyc >= BUSY - 3 && cyc <= BUSY + 1, "R9", cyc, BUSY);
        cs_off();
        expect_word(7'd5, 16'h1234, "R2");
    endtask

    task automatic t_seq_wrap();
        logic [31:0] v;
        prog(2'b01, 7'd63, 16'hA5C3, 1, 1, "R5");
        prog(2'b01, 7'd0, 16'h0F1E, 1, 1, "R5");
        rd(7'd63, 32, v, "R5");
        chk(v == 32'hA5C30F1E, "R5", v, 32'hA5C30F1E);
    endtask

    task automatic t_org();
        org = 1'b0;
        expect_word(7'd10, 16'h0034, "R6");
        expect_word(7'd11, 16'h0012, "R6");
        prog(2'b01, 7'd11, 16'h00C3, 1, 1, "R6");
        org = 1'b1;
        expect_word(7'd5, 16'hC334, "R6");
    endtask

    task automatic t_erase();
        prog(2'b11, 7'd5, 16'h0, 0, 1, "R7");
        expect_word(7'd5, 16'hFFFF, "R7");
    endtask

    task automatic t_abort();
        cs_on();
        frame(2'b01, 7'd7);
        send(16'h0, 10);
        cs_off();
        expect_word(7'd7, 16'hFFFF, "R8");
    endtask

    task automatic t_hiz();
        cs_on();
        frame(2'b10, 7'd0);
        pulse(1'b0);
        @(negedge clk) cs = 1'b0;
        #1 chk(!so_en, "R10", so_en, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        cs_on();
        frame(2'b01, 7'd9);
        send(16'h0F0F, 16);
        cs_off();
        cs_on();
        frame(2'b01, 7'd9);
        send(16'h7777, 16);
        chk(!s_en, "R11", s_en, 0);
        cs_off();
        repeat (BUSY + 5) @(negedge clk);
        expect_word(7'd9, 16'h0F0F, "R11");
    endtask

    task automatic t_all();
        prog(2'b00, 7'h10, 16'hBEEF, 1, 1, "R7");
        expect_word(7'd0, 16'hBEEF, "R7");
        expect_word(7'd40, 16'hBEEF, "R7");
        prog(2'b00, 7'h20, 16'h0, 0, 1, "R7");
        expect_word(7'd3, 16'hFFFF, "R7");
        prog(2'b00, 7'h00, 16'h0, 0, 0, "R3");
        prog(2'b01, 7'd2, 16'h1111, 1, 0, "R3");
        expect_word(7'd2, 16'hFFFF, "R3");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_start_qual();
        t_protect();
        t_write_busy();
        t_seq_wrap();
        t_org();
        t_erase();
        t_abort();
        t_hiz();
        t_busy_ignore();
        t_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule